// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Tracker

This block picks which way a 4-way set-associative cache should evict from a set. Each set keeps three history bits arranged as a two-level binary tree. The root bit records which half of the set was touched last. Each of the two lower bits records which way inside its half was touched last. Every time the cache touches a way, the two tree bits on that way's path are overwritten and the bit for the other half is left as it was. The victim is found by starting at the root and going, at each level, the opposite way from the recorded direction. The result is close to least-recently-used order, at three bits per set.

The cache drives an access strobe with a set index and a way number whenever a lookup hits or a fill lands. It reads the victim for any set through a separate query index. Access and query are control pins, not a data stream. The tracker has no ready output and never applies back-pressure: it takes one access on every cycle in which the strobe is high. The victim output is a combinational read of the stored tree for the queried set. An access is written at the clock edge, so its effect shows in the victim from the following cycle on. Reset is synchronous and active low.

Top module: `plru_tracker`

## Requirements
- R1: While reset is applied, and after it is released, every set reports way 3 as its victim until that set is accessed.
- R2: In the cycle after an access to way W of set S, querying S returns a victim whose upper bit is the inverse of bit 1 of W.
- R3: In the cycle after an access to way W of set S, querying S never returns W as the victim.
- R4: An access changes only the root bit and the lower bit of the half it lands in. The lower bit of the other half keeps its value. Example: in a set where B1=0 and B2=0, accesses to way 3 and then way 1 give victim 2.
- R5: Starting from any state, the accesses 3, 0, 2, 1 to one set leave way 3 as that set's victim.
- R6: An access to set S leaves the victim of every other set unchanged.
- R7: While the access strobe is low, the set and way inputs have no effect on any set's stored state.
- R8: The victim reflects only accesses taken at earlier clock edges. An access to the queried set in the same cycle does not change the victim shown in that cycle.
- R9: Tree bits are B0 (root), B1 (the half holding ways 2 and 3) and B2 (the half holding ways 0 and 1). An access to way {b1,b0} writes B0=b1, and writes B1=b0 when b1 is 1 or B2=b0 when b1 is 0. The victim is {~B0, ~B1} when B0 is 0 and {~B0, ~B2} when B0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state is updated on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all tree bits |
| acc_valid | input | 1 | High when an access is to be recorded in this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way number of the access |
| qry_set | input | SET_W | Set whose victim is reported |
| victim_way | output | 2 | Way to evict from the queried set |

## Verification
The assertions assume the cache keeps every set index below NUM_SETS. They also assume the way number is a known value whenever the strobe is high. When the strobe is low, the way number and set index may hold any value. The bench only ever drives indices inside the default set count. On idle cycles it deliberately puts non-zero, arbitrary set and way values on those pins, so that any leak of ignored inputs into the state would change a victim it later reads back.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);
  localparam int TREE_BITS = WAYS - 1;

  typedef logic [WAY_W-1:0]     way_t;
  // bit 0: root, bit 1: upper half (ways 2,3), bit 2: lower half (ways 0,1)
  typedef logic [TREE_BITS-1:0] tree_t;

  localparam int ROOT_BIT = 0;
  localparam int HI_BIT   = 1;
  localparam int LO_BIT   = 2;
endpackage

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
(
  input  tree_t cur_tree,
  input  way_t  way,
  output tree_t nxt_tree
);
  always_comb begin
    nxt_tree           = cur_tree;
    nxt_tree[ROOT_BIT] = way[1];
    if (way[1]) nxt_tree[HI_BIT] = way[0];
    else        nxt_tree[LO_BIT] = way[0];
  end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  tree_t tree,
  output way_t  victim
);
  logic half;
  always_comb begin
    half   = ~tree[ROOT_BIT];
    victim = {half, half ? ~tree[HI_BIT] : ~tree[LO_BIT]};
  end
endmodule

// File: rtl/plru_tracker.sv
module plru_tracker
  import plru_pkg::*;
#(
  parameter  int NUM_SETS = 8,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [1:0]       acc_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [1:0]       victim_way
);
  tree_t tree_q [NUM_SETS];
  tree_t acc_tree, acc_tree_nxt, qry_tree;

  // read the tree of the accessed set and of the queried set
  always_comb begin
    acc_tree = '0;
    qry_tree = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (acc_set == SET_W'(i)) acc_tree = tree_q[i];
      if (qry_set == SET_W'(i)) qry_tree = tree_q[i];
    end
  end

  plru_tree_update u_upd (
    .cur_tree (acc_tree),
    .way      (way_t'(acc_way)),
    .nxt_tree (acc_tree_nxt)
  );

  generate
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic wr_en;
      assign wr_en = acc_valid && (acc_set == SET_W'(s));
      always_ff @(posedge clk) begin
        if (!rst_n)     tree_q[s] <= '0;
        else if (wr_en) tree_q[s] <= acc_tree_nxt;
      end
    end
  endgenerate

  way_t victim_w;
  plru_victim_pick u_pick (
    .tree   (qry_tree),
    .victim (victim_w)
  );
  assign victim_way = victim_w;
endmodule

// File: rtl/plru_tracker_chk.sv
module plru_tracker_chk #(
  parameter int SET_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic [1:0]       acc_way,
  input logic [SET_W-1:0] qry_set,
  input logic [1:0]       victim_way
);
  // R1: first cycle out of reset shows the reset victim
  p_reset_victim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> victim_way == 2'd3);

  // R2: upper victim bit points away from the half just touched
  p_root_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (qry_set != $past(acc_set)) ||
                  (victim_way[1] == ~$past(acc_way[1])));

  // R3: the way just touched is never the victim
  p_not_recent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (qry_set != $past(acc_set)) ||
                  (victim_way != $past(acc_way)));

  // R6 / R7: a set not written at this edge keeps its victim
  p_untouched_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || (acc_set != qry_set)) |=>
      (qry_set != $past(qry_set)) || $stable(victim_way));

  // R9: output always a defined way
  p_known_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(victim_way));
endmodule

bind plru_tracker plru_tracker_chk #(.SET_W(SET_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_set    (acc_set),
  .acc_way    (acc_way),
  .qry_set    (qry_set),
  .victim_way (victim_way)
);

// File: tb/sim_plru_tracker.sv
module sim_plru_tracker;
  localparam int SETS = 8;
  localparam int SW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [1:0]    acc_way = '0;
  logic [SW-1:0] qry_set = '0;
  logic [1:0]    victim_way;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  plru_tracker #(.NUM_SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<5000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_ne(input string req, input logic [1:0] act, input logic [1:0] bad);
    checks = checks + 1;
    if (act === bad) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=not %0d", req, act, bad);
    end
  endtask

  // one cycle: drive at negedge, read the old-state victim, then the edge commits
  task automatic step(input logic v, input logic [SW-1:0] s, input logic [1:0] w,
                      input logic [SW-1:0] q);
    @(negedge clk);
    acc_valid = v; acc_set = s; acc_way = w; qry_set = q;
    #1;
  endtask

  // {valid, set[2:0], way[1:0], query[2:0], expected[1:0]}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 3'd0, 2'd3, 3'd0, 2'd3},  // R1 reset state, then touch 3
    {1'b1, 3'd0, 2'd0, 3'd0, 2'd1},  // R9
    {1'b1, 3'd0, 2'd2, 3'd0, 2'd2},  // R9
    {1'b1, 3'd0, 2'd1, 3'd0, 2'd1},  // R9
    {1'b0, 3'd0, 2'd0, 3'd0, 2'd3},  // R5 after 3,0,2,1
    {1'b1, 3'd5, 2'd2, 3'd0, 2'd3},  // R6 set0 untouched
    {1'b0, 3'd5, 2'd3, 3'd5, 2'd1},  // R7 idle strobe with junk
    {1'b0, 3'd0, 2'd0, 3'd5, 2'd1},  // R7 junk not recorded
    {1'b1, 3'd5, 2'd0, 3'd0, 2'd3},  // R6
    {1'b1, 3'd5, 2'd3, 3'd5, 2'd3},  // R8 same-cycle access hidden
    {1'b1, 3'd5, 2'd1, 3'd5, 2'd1},  // R8
    {1'b0, 3'd2, 2'd2, 3'd5, 2'd2},  // R4 upper-half bit kept
    {1'b1, 3'd7, 2'd2, 3'd7, 2'd3},  // R1 last set
    {1'b0, 3'd6, 2'd1, 3'd7, 2'd1}   // R9
  };

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R1 during reset", victim_way, 2'd3);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9:7], VEC[i][6:5], VEC[i][4:2]);
      check($sformatf("R9 vector %0d", i), victim_way, VEC[i][1:0]);
    end

    // R1: reset mid-run clears all sets
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int q = 0; q < SETS; q++) begin
      step(1'b0, SW'(q), 2'd0, SW'(q));
      check($sformatf("R1 set %0d after reset", q), victim_way, 2'd3);
    end

    // R2 / R3: each way touched then read back next cycle
    for (int w = 0; w < 4; w++) begin
      step(1'b1, 3'd3, 2'(w), 3'd3);
      step(1'b0, 3'd0, 2'd0, 3'd3);
      check($sformatf("R2 upper bit after way %0d", w), {1'b0, victim_way[1]},
            {1'b0, ~w[1]});
      check_ne($sformatf("R3 after way %0d", w), victim_way, 2'(w));
    end

    // R4: B1=B2=0 then ways 3 and 1 -> victim 2
    step(1'b1, 3'd4, 2'd0, 3'd4);
    step(1'b1, 3'd4, 2'd2, 3'd4);
    step(1'b1, 3'd4, 2'd3, 3'd4);
    step(1'b1, 3'd4, 2'd1, 3'd4);
    step(1'b0, 3'd0, 2'd0, 3'd4);
    check("R4 sibling bit kept", victim_way, 2'd2);

    // R5: from a scrambled state, sequence 3,0,2,1 gives way 3
    step(1'b1, 3'd6, 2'd1, 3'd6);
    step(1'b1, 3'd6, 2'd2, 3'd6);
    step(1'b1, 3'd6, 2'd3, 3'd6);
    step(1'b1, 3'd6, 2'd0, 3'd6);
    step(1'b1, 3'd6, 2'd2, 3'd6);
    step(1'b1, 3'd6, 2'd1, 3'd6);
    step(1'b0, 3'd1, 2'd3, 3'd6);
    check("R5 sequence victim", victim_way, 2'd3);

    // R6: set 4 still holds its value after set 6 activity
    step(1'b0, 3'd0, 2'd0, 3'd4);
    check("R6 neighbour unchanged", victim_way, 2'd2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule